// File: doc/BRIEF.md
# Self-Timed Dual-Rail Full Adder

This block adds two one-bit operands and a carry-in, with every value carried on a pair of rails instead of one wire. A pair with neither rail set means "no value yet" (NULL), and a pair with exactly one rail set carries a bit. The caller alternates between two phases. In a DATA wavefront all inputs move from NULL to values. In a NULL wavefront they all return to NULL. No clock edge marks when a result is ready: the block asserts a completion output once both result pairs hold values, and drops it once both have gone back to NULL.

Internally there are four threshold gates with hysteresis. The two carry rails each use a 2-of-3 gate. The two sum rails each use a 3-of-4 gate in which the opposite carry rail counts twice. Every gate is modelled as one flip-flop on the system clock so the block can be synthesized. A gate output rises when the weighted count of its set inputs reaches the threshold. It then holds until every one of its inputs is clear. This arrangement makes the carry rail one clock behind its inputs, the sum rail two clocks behind, and completion three clocks behind. A separate flag reports any input pair that has both rails set.

Top module: `ncl_full_adder`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, all result rails, `done` and `code_err` are 0.
- R2: Every pair is two bits `{true_rail, false_rail}`: 2'b00 is NULL, 2'b01 is logic 0, 2'b10 is logic 1, and 2'b11 is illegal. One clock after all three inputs are DATA, `co_rails` holds the majority of the three input bits in this encoding.
- R3: Two clocks after all three inputs are DATA, `s_rails` holds the XOR of the three input bits, and neither result pair is ever 2'b11 under legal inputs.
- R4: While any input pair is NULL, `s_rails` stays NULL and `done` stays low, even when the other inputs are DATA.
- R5: A carry rail rises as soon as two input pairs are DATA with the same bit, one clock later, without waiting for the third input.
- R6: Once a result rail is set, it stays set while any input of its gate is still set. A partial NULL wavefront therefore leaves `s_rails`, `co_rails` and `done` unchanged.
- R7: `done` rises one clock after both result pairs are valid DATA. It falls one clock after both result pairs are NULL, and otherwise keeps its value.
- R8: `code_err` is 1 on the clock after any input pair equals 2'b11, and 0 on the clock after no input pair does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that updates every gate |
| rst_n | input | 1 | Synchronous active-low reset |
| x_rails | input | 2 | First addend, dual-rail |
| y_rails | input | 2 | Second addend, dual-rail |
| ci_rails | input | 2 | Carry-in, dual-rail |
| s_rails | output | 2 | Sum, dual-rail |
| co_rails | output | 2 | Carry-out, dual-rail |
| done | output | 1 | Completion: high after both results are DATA, low after both are NULL |
| code_err | output | 1 | An input pair was 2'b11 on the previous clock |

## Verification
The bench drives all eight operand combinations as full DATA wavefronts separated by NULL wavefronts. Before each third operand arrives it stops at partial steps. A sum gate with too low a threshold, or with the wrong carry weight, would produce a sum rail during those partial steps or on the wrong combinations. The bench also returns only one input pair to NULL, which catches gates whose hysteresis releases on any clear input rather than on all clear inputs. It checks that `done` neither lags nor drops early, and that an illegal 2'b11 pair raises the error flag for exactly the clocks it is present.

// File: rtl/ncl_fa_pkg.sv
// Package: shared dual-rail encoding for the self-timed adder.
// Assumes bit 1 of a pair is the true rail and bit 0 the false rail.
package ncl_fa_pkg;
    typedef logic [1:0] rail_t;

    localparam rail_t RAIL_NULL  = 2'b00;
    localparam rail_t RAIL_ZERO  = 2'b01;
    localparam rail_t RAIL_ONE   = 2'b10;
    localparam rail_t RAIL_BAD   = 2'b11;

    // Width of one weight field in a threshold gate's weight vector.
    localparam int unsigned WEIGHT_W = 4;

    // True when the pair carries a legal bit value.
    function automatic logic is_data(rail_t r);
        return (r == RAIL_ZERO) || (r == RAIL_ONE);
    endfunction
endpackage

// File: rtl/ncl_th_gate.sv
// Module: weighted threshold gate with hysteresis, as one flip-flop.
// The output sets when the weighted count of set inputs reaches THRESH.
// It clears only when every input is clear, and otherwise holds.
// Assumes the inputs obey the DATA/NULL alternation; weights are unsigned.
module ncl_th_gate
    import ncl_fa_pkg::*;
#(
    parameter int unsigned N       = 3,
    parameter int unsigned THRESH  = 2,
    parameter logic [N*WEIGHT_W-1:0] WEIGHTS = {N{4'd1}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] in_rails,
    output logic         q
);
    localparam int unsigned SUM_W = WEIGHT_W + $clog2(N + 1);

    logic [SUM_W-1:0] weighted;

    // Weighted count of the inputs that are currently set.
    always_comb begin
        weighted = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (in_rails[i]) begin
                weighted = weighted + SUM_W'(WEIGHTS[i*WEIGHT_W +: WEIGHT_W]);
            end
        end
    end

    // Set on threshold, clear on all-NULL, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (weighted >= SUM_W'(THRESH)) begin
            q <= 1'b1;
        end else if (in_rails == '0) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/ncl_completion.sv
// Module: completion detector over PAIRS dual-rail pairs.
// Rises when every pair is valid DATA, falls when every pair is NULL,
// and holds in between, like a C-element over the pair states.
module ncl_completion
    import ncl_fa_pkg::*;
#(
    parameter int unsigned PAIRS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*PAIRS-1:0] rails,
    output logic               done
);
    logic [PAIRS-1:0] pair_data;
    logic [PAIRS-1:0] pair_null;

    // Classify each pair separately.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_data[p] = is_data(rails[2*p +: 2]);
        assign pair_null[p] = (rails[2*p +: 2] == RAIL_NULL);
    end

    // Completion state with hysteresis between full DATA and full NULL.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (&pair_data) begin
            done <= 1'b1;
        end else if (&pair_null) begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/ncl_code_check.sv
// Module: flags any input pair that has both rails set.
// The flag is registered and reflects the previous clock's inputs only.
module ncl_code_check
    import ncl_fa_pkg::*;
#(
    parameter int unsigned PAIRS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*PAIRS-1:0] rails,
    output logic               err
);
    logic [PAIRS-1:0] pair_bad;

    // Detect the illegal code per pair.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_bad[p] = (rails[2*p +: 2] == RAIL_BAD);
    end

    // Register the OR of the per-pair detections.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else begin
            err <= |pair_bad;
        end
    end
endmodule

// File: rtl/ncl_full_adder.sv
// Module: self-timed dual-rail full adder.
// Carry rail b is a 2-of-3 gate over rail b of the three inputs.
// Sum rail b is a 3-of-4 gate over rail b of the three inputs plus the
// opposite carry rail, which has weight 2. Completion and illegal-code
// detection sit beside the gates. Assumes the caller alternates full
// DATA and full NULL wavefronts on the inputs.
module ncl_full_adder
    import ncl_fa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] x_rails,
    input  logic [1:0] y_rails,
    input  logic [1:0] ci_rails,
    output logic [1:0] s_rails,
    output logic [1:0] co_rails,
    output logic       done,
    output logic       code_err
);
    localparam int unsigned RAILS = 2;

    // One carry gate and one sum gate per rail polarity.
    for (genvar b = 0; b < RAILS; b++) begin : g_rail
        ncl_th_gate #(
            .N       (3),
            .THRESH  (2),
            .WEIGHTS ({4'd1, 4'd1, 4'd1})
        ) u_carry (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_rails ({ci_rails[b], y_rails[b], x_rails[b]}),
            .q        (co_rails[b])
        );

        ncl_th_gate #(
            .N       (4),
            .THRESH  (3),
            .WEIGHTS ({4'd2, 4'd1, 4'd1, 4'd1})
        ) u_sum (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_rails ({co_rails[RAILS-1-b], ci_rails[b], y_rails[b], x_rails[b]}),
            .q        (s_rails[b])
        );
    end

    ncl_completion #(.PAIRS(2)) u_done (
        .clk   (clk),
        .rst_n (rst_n),
        .rails ({co_rails, s_rails}),
        .done  (done)
    );

    ncl_code_check #(.PAIRS(3)) u_check (
        .clk   (clk),
        .rst_n (rst_n),
        .rails ({ci_rails, y_rails, x_rails}),
        .err   (code_err)
    );
endmodule

// File: rtl/ncl_full_adder_checker.sv
// Module: protocol assertions for the dual-rail adder, bound to the top.
// Assumes the DATA/NULL alternation on the inputs.
module ncl_full_adder_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] x_rails,
    input logic [1:0] y_rails,
    input logic [1:0] ci_rails,
    input logic [1:0] s_rails,
    input logic [1:0] co_rails,
    input logic       done,
    input logic       code_err
);
    // R1: reset clears the results and completion on the next clock.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (s_rails == 2'b00 && co_rails == 2'b00 && !done && !code_err));

    // R3: result pairs never carry the illegal code.
    assert_onehot_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_rails) && $onehot0(co_rails));

    // R4: a sum rail only rises after all three inputs were DATA.
    assert_sum_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|s_rails) |-> $past(x_rails != 2'b00 && y_rails != 2'b00 && ci_rails != 2'b00));

    // R6: the true sum rail holds while any of its gate inputs is set.
    assert_sum_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rails[1] && (x_rails[1] || y_rails[1] || ci_rails[1] || co_rails[0])) |=> s_rails[1]);

    // R7: completion holds while a result pair is still DATA.
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (s_rails != 2'b00 || co_rails != 2'b00)) |=> done);

    // R8: an illegal input pair raises the flag one clock later.
    assert_err_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (x_rails == 2'b11 || y_rails == 2'b11 || ci_rails == 2'b11) |=> code_err);
endmodule

bind ncl_full_adder ncl_full_adder_checker u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .x_rails  (x_rails),
    .y_rails  (y_rails),
    .ci_rails (ci_rails),
    .s_rails  (s_rails),
    .co_rails (co_rails),
    .done     (done),
    .code_err (code_err)
);

// File: tb/ncl_full_adder_tb.sv
`timescale 1ns/100ps
// Bench: behavioural per-clock reference model plus directed wavefront checks.
module ncl_full_adder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] x_rails = 2'b00;
    logic [1:0] y_rails = 2'b00;
    logic [1:0] ci_rails = 2'b00;
    logic [1:0] s_rails;
    logic [1:0] co_rails;
    logic       done;
    logic       code_err;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Reference state.
    logic [1:0] m_s = 2'b00;
    logic [1:0] m_co = 2'b00;
    logic       m_done = 1'b0;
    logic       m_err = 1'b0;

    always #2.5 clk = ~clk;

    ncl_full_adder dut_i (
        .clk(clk), .rst_n(rst_n), .x_rails(x_rails), .y_rails(y_rails),
        .ci_rails(ci_rails), .s_rails(s_rails), .co_rails(co_rails),
        .done(done), .code_err(code_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] enc(input bit v);
        return v ? 2'b10 : 2'b01;
    endfunction

    // Reference update: counts of set true/false rails decide each result.
    always @(posedge clk) begin
        int nt, nf, w1, w0;
        nt = int'(x_rails[1]) + int'(y_rails[1]) + int'(ci_rails[1]);
        nf = int'(x_rails[0]) + int'(y_rails[0]) + int'(ci_rails[0]);
        w1 = nt + 2 * int'(m_co[0]);
        w0 = nf + 2 * int'(m_co[1]);
        if (!rst_n) begin
            m_s <= 2'b00; m_co <= 2'b00; m_done <= 1'b0; m_err <= 1'b0;
        end else begin
            m_co[1] <= (nt >= 2) ? 1'b1 : (nt == 0) ? 1'b0 : m_co[1];
            m_co[0] <= (nf >= 2) ? 1'b1 : (nf == 0) ? 1'b0 : m_co[0];
            m_s[1]  <= (w1 >= 3) ? 1'b1 : (w1 == 0) ? 1'b0 : m_s[1];
            m_s[0]  <= (w0 >= 3) ? 1'b1 : (w0 == 0) ? 1'b0 : m_s[0];
            if ((m_s == 2'b01 || m_s == 2'b10) && (m_co == 2'b01 || m_co == 2'b10))
                m_done <= 1'b1;
            else if (m_s == 2'b00 && m_co == 2'b00)
                m_done <= 1'b0;
            m_err <= (x_rails == 2'b11) || (y_rails == 2'b11) || (ci_rails == 2'b11);
        end
    end

    // Per-clock comparison, one time unit after the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            check(co_rails == m_co, "R2 carry vs model", co_rails, m_co);
            check(s_rails == m_s, "R3 sum vs model", s_rails, m_s);
            check(done == m_done, "R7 done vs model", done, m_done);
            check(code_err == m_err, "R8 err vs model", code_err, m_err);
        end
    end

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Directed stimulus and checks.
    initial begin
        waitn(3);
        check(s_rails == 2'b00 && co_rails == 2'b00 && !done && !code_err,
              "R1 reset state", {s_rails, co_rails}, 0);
        rst_n = 1'b1;
        waitn(1);
        check(s_rails == 2'b00 && co_rails == 2'b00 && !done,
              "R1 after release", {s_rails, co_rails}, 0);

        for (int v = 0; v < 8; v++) begin
            bit a, b, c;
            a = v[0]; b = v[1]; c = v[2];
            x_rails = enc(a);
            waitn(3);
            check(s_rails == 2'b00 && !done, "R4 one input DATA", {s_rails, done}, 0);
            y_rails = enc(b);
            waitn(3);
            check(s_rails == 2'b00 && !done, "R4 two inputs DATA", {s_rails, done}, 0);
            check(co_rails == ((a == b) ? enc(a) : 2'b00), "R5 early carry",
                  co_rails, (a == b) ? enc(a) : 2'b00);
            ci_rails = enc(c);
            waitn(4);
            check(co_rails == enc((a & b) | (a & c) | (b & c)), "R2 carry out",
                  co_rails, enc((a & b) | (a & c) | (b & c)));
            check(s_rails == enc(a ^ b ^ c), "R3 sum out", s_rails, enc(a ^ b ^ c));
            check(done, "R7 done set", done, 1);
            x_rails = 2'b00;
            waitn(3);
            check(s_rails == enc(a ^ b ^ c) && done, "R6 partial NULL hold",
                  {s_rails, done}, {enc(a ^ b ^ c), 1'b1});
            y_rails = 2'b00;
            ci_rails = 2'b00;
            waitn(4);
            check(s_rails == 2'b00 && co_rails == 2'b00 && !done, "R7 NULL wave",
                  {s_rails, co_rails, done}, 0);
        end

        x_rails = 2'b11;
        waitn(2);
        check(code_err, "R8 illegal pair flagged", code_err, 1);
        check(s_rails == 2'b00 && co_rails == 2'b00, "R8 no result from lone bad pair",
              {s_rails, co_rails}, 0);
        x_rails = 2'b00;
        waitn(2);
        check(!code_err, "R8 flag clears", code_err, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            tests++;
            fails++;
            finished = 1'b1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule